// File: doc/BRIEF.md
# Stored-Digit Radix-4 Constant Multiplier

This block multiplies a signed two's-complement operand by one of a small, fixed set of coefficients. Each coefficient sits in an internal table already converted to radix-4 signed digits, so nothing on the multiply path recodes the coefficient. An index input picks the table entry. The stored digits drive the row selectors directly, the rows are summed, and the full-width product is registered.

The low digits of each coefficient come from a four-value set, so each one needs only two bits of storage. By default the set is {-1, 0, +1, +2}, and a parameter selects the mirrored set {-2, -1, 0, +1}. The top digit may take any value from -2 to +2, which lets the whole signed range of the coefficient be represented. That digit is stored as three flag bits (negate, single, double). A stored word is therefore W+1 bits. A negative digit forms its row as the inverted operand plus a correction one at the row's lowest weight. Every row is sign-extended to the 2W-bit product width before the sum.

A caller presents the operand, the index and a valid strobe in one cycle. One cycle later the product and a matching valid appear. A new operand can be accepted every cycle.

Top module: `sdr4_coef_mul`

## Requirements
- R1: When `in_valid` is high, `out_prod` on the next cycle equals the signed 2W-bit product of `in_x` and table entry `in_idx`.
- R2: Table entry k holds: k=0: -2^(W-1); k=1: 2^(W-1)-1; k=2: 0; k=3: -1; every k>=4: the low W bits of k*0x9E3779B9, read as signed.
- R3: An index at or above NCOEF (12 by default, with a 4-bit index) acts as a zero coefficient, so the product is 0.
- R4: `out_valid` equals `in_valid` delayed by exactly one cycle.
- R5: While `in_valid` is low, `out_prod` keeps its last value whatever `in_x` and `in_idx` do.
- R6: While reset (`rst_n` low) is asserted, `out_valid` and `out_prod` are 0.
- R7: The extreme operands -2^(W-1) and 2^(W-1)-1 give exact products against the extreme coefficients, for example (-2^(W-1))*(-2^(W-1)) = 2^(2W-2).
- R8: An instance with MIRROR=1 stores low digits as 00=0, 01=+1, 10=-2, 11=-1 and gives the same products as the default instance, which stores 00=0, 01=+1, 10=+2, 11=-1. In both, the top digit is stored as bits {neg, one, two} above the low digits.
- R9: Operands presented on consecutive cycles each yield their own product, one per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and index are valid this cycle |
| in_x | input | W | Signed operand |
| in_idx | input | IDXW | Coefficient table index |
| out_valid | output | 1 | Product is valid |
| out_prod | output | 2W | Signed product |

## Verification
A stored code decoded to the wrong selector changes the product only for coefficients that contain that digit. For this reason every table entry is exercised against several operands, including both extremes, and both digit sets are compared. A missing correction bit or a wrong sign extension shows as a product that is wrong by a power of two or by a sign. The fault appears on the cycle after the operand is presented. A fault in the output register shows at once as a lost hold or a valid strobe that is shifted by a cycle.

// File: rtl/sdr4_pkg.sv
package sdr4_pkg;

    // Row selector: the digit magnitude is one or two, plus a negate flag.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } dsel_t;

    // Decode a stored 2-bit low digit (R8 code tables).
    function automatic dsel_t dec_low(input logic [1:0] code, input logic mirror);
        dsel_t s;
        s = '0;
        unique case (code)
            2'b00: s = '0;
            2'b01: s = '{neg: 1'b0, one: 1'b1, two: 1'b0};
            2'b10: s = mirror ? '{neg: 1'b1, one: 1'b0, two: 1'b1}
                              : '{neg: 1'b0, one: 1'b0, two: 1'b1};
            default: s = '{neg: 1'b1, one: 1'b1, two: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdr4_coef_rom.sv
module sdr4_coef_rom #(
    parameter int W      = 16,
    parameter int NCOEF  = 12,
    parameter int IDXW   = 4,
    parameter bit MIRROR = 1'b0
) (
    input  logic [IDXW-1:0] idx_i,
    output logic [W:0]      word_o
);
    localparam int ND = W / 2;
    localparam int RW = W + 1;

    // Coefficient value of entry k (R2).
    function automatic logic [W-1:0] coef_value(input int k);
        logic [63:0] h;
        h = 64'(k) * 64'h9E37_79B9;
        case (k)
            0:       return {1'b1, {(W-1){1'b0}}};
            1:       return {1'b0, {(W-1){1'b1}}};
            2:       return '0;
            3:       return '1;
            default: return h[W-1:0];
        endcase
    endfunction

    // Conversion to stored digits, evaluated on constants only.
    function automatic logic [RW-1:0] encode(input logic [W-1:0] c);
        logic [RW-1:0] w;
        int            cy;
        int            v;
        w  = '0;
        cy = 0;
        for (int i = 0; i < ND - 1; i++) begin
            v = int'(c[2*i +: 2]) + cy;
            if (!MIRROR) begin
                case (v)
                    0:       begin w[2*i +: 2] = 2'b00; cy = 0; end
                    1:       begin w[2*i +: 2] = 2'b01; cy = 0; end
                    2:       begin w[2*i +: 2] = 2'b10; cy = 0; end
                    3:       begin w[2*i +: 2] = 2'b11; cy = 1; end
                    default: begin w[2*i +: 2] = 2'b00; cy = 1; end
                endcase
            end else begin
                case (v)
                    0:       begin w[2*i +: 2] = 2'b00; cy = 0; end
                    1:       begin w[2*i +: 2] = 2'b01; cy = 0; end
                    2:       begin w[2*i +: 2] = 2'b10; cy = 1; end
                    3:       begin w[2*i +: 2] = 2'b11; cy = 1; end
                    default: begin w[2*i +: 2] = 2'b00; cy = 1; end
                endcase
            end
        end
        v = (c[W-1] ? -2 : 0) + int'(c[W-2]) + cy;
        w[RW-1]   = (v < 0);
        w[RW-2]   = (v == 1) || (v == -1);
        w[RW-3]   = (v == 2) || (v == -2);
        return w;
    endfunction

    logic [RW-1:0] rom [NCOEF];

    for (genvar k = 0; k < NCOEF; k++) begin : g_rom
        assign rom[k] = encode(coef_value(k));
    end

    // Out-of-range index reads an all-zero word, i.e. a zero coefficient (R3).
    always_comb begin
        word_o = '0;
        for (int k = 0; k < NCOEF; k++) begin
            if (int'(idx_i) == k) word_o = rom[k];
        end
    end

endmodule

// File: rtl/sdr4_pp_gen.sv
module sdr4_pp_gen
    import sdr4_pkg::*;
#(
    parameter int W      = 16,
    parameter bit MIRROR = 1'b0
) (
    input  logic [W-1:0]     x_i,
    input  logic [W:0]       word_i,
    output logic [2*W-1:0]   rows_o [W/2+1]
);
    localparam int ND = W / 2;
    localparam int PW = 2 * W;

    logic [PW-1:0] xs;
    logic [ND-1:0] negs;

    assign xs = {{W{x_i[W-1]}}, x_i};

    for (genvar i = 0; i < ND; i++) begin : g_row
        dsel_t         sel;
        logic [PW-1:0] base;

        if (i < ND - 1) begin : g_low
            assign sel = dec_low(word_i[2*i +: 2], MIRROR);
        end else begin : g_top
            assign sel = dsel_t'(word_i[W -: 3]);
        end

        always_comb begin
            if (sel.two)      base = xs << 1;
            else if (sel.one) base = xs;
            else              base = '0;
        end

        // Negative digit: inverted multiple now, +1 at weight 4^i later.
        assign rows_o[i] = (sel.neg ? ~base : base) << (2 * i);
        assign negs[i]   = sel.neg;
    end

    // Correction row gathers every negated row's +1.
    always_comb begin
        rows_o[ND] = '0;
        for (int i = 0; i < ND; i++) begin
            rows_o[ND][2*i] = negs[i];
        end
    end

endmodule

// File: rtl/sdr4_sum_tree.sv
module sdr4_sum_tree #(
    parameter int PW = 32,
    parameter int NR = 9
) (
    input  logic [PW-1:0] rows_i [NR],
    output logic [PW-1:0] sum_o
);
    localparam int LV = (NR > 1) ? $clog2(NR) : 1;
    localparam int P  = 1 << LV;

    // Heap layout: leaves at P..2P-1, root at 1.
    logic [PW-1:0] node [1:2*P-1];

    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < NR) begin : g_used
            assign node[P + j] = rows_i[j];
        end else begin : g_pad
            assign node[P + j] = '0;
        end
    end

    for (genvar k = 1; k < P; k++) begin : g_add
        assign node[k] = node[2*k] + node[2*k + 1];
    end

    assign sum_o = node[1];

endmodule

// File: rtl/sdr4_coef_mul.sv
module sdr4_coef_mul #(
    parameter int W      = 16,
    parameter int NCOEF  = 12,
    parameter int IDXW   = $clog2(NCOEF),
    parameter bit MIRROR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      in_x,
    input  logic [IDXW-1:0]   in_idx,
    output logic              out_valid,
    output logic [2*W-1:0]    out_prod
);
    localparam int ND = W / 2;
    localparam int PW = 2 * W;
    localparam int NR = ND + 1;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } st_t;

    st_t           st_d, st_q;
    logic [W:0]    word;
    logic [PW-1:0] rows [NR];
    logic [PW-1:0] sum;

    sdr4_coef_rom #(.W(W), .NCOEF(NCOEF), .IDXW(IDXW), .MIRROR(MIRROR)) rom_i (
        .idx_i  (in_idx),
        .word_o (word)
    );

    sdr4_pp_gen #(.W(W), .MIRROR(MIRROR)) ppg_i (
        .x_i    (in_x),
        .word_i (word),
        .rows_o (rows)
    );

    sdr4_sum_tree #(.PW(PW), .NR(NR)) tree_i (
        .rows_i (rows),
        .sum_o  (sum)
    );

    // R4/R5: valid follows the input; product loads only on valid.
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.prod = sum;
    end

    // R6: asynchronous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_prod  = st_q.prod;

endmodule

// File: rtl/sdr4_coef_mul_chk.sv
module sdr4_coef_mul_chk #(
    parameter int W     = 16,
    parameter int NCOEF = 12,
    parameter int IDXW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [W-1:0]    in_x,
    input logic [IDXW-1:0] in_idx,
    input logic            out_valid,
    input logic [2*W-1:0]  out_prod
);
    // R4
    p_valid_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R5
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_prod));
    // R3
    p_zero_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (int'(in_idx) >= NCOEF)) |=> (out_prod == '0));
    // R1: a zero operand gives a zero product for any entry
    p_zero_operand_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_x == '0)) |=> (out_prod == '0));
    // R2: entry 2 is the zero coefficient
    p_zero_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (int'(in_idx) == 2)) |=> (out_prod == '0));
endmodule

bind sdr4_coef_mul sdr4_coef_mul_chk #(.W(W), .NCOEF(NCOEF), .IDXW(IDXW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_idx    (in_idx),
    .out_valid (out_valid),
    .out_prod  (out_prod)
);

// File: tb/sdr4_coef_mul_tb_top.sv
module sdr4_coef_mul_tb_top;
    localparam int W     = 16;
    localparam int NCOEF = 12;
    localparam int IDXW  = 4;
    localparam int PW    = 2 * W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [W-1:0]    in_x = '0;
    logic [IDXW-1:0] in_idx = '0;
    logic            out_valid, out_valid_m;
    logic [PW-1:0]   out_prod, out_prod_m;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sdr4_coef_mul #(.W(W), .NCOEF(NCOEF), .IDXW(IDXW), .MIRROR(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_idx(in_idx),
        .out_valid(out_valid), .out_prod(out_prod));

    sdr4_coef_mul #(.W(W), .NCOEF(NCOEF), .IDXW(IDXW), .MIRROR(1'b1)) dut_m_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_idx(in_idx),
        .out_valid(out_valid_m), .out_prod(out_prod_m));

    // Coefficient table from R2, zero beyond the table (R3).
    function automatic logic signed [W-1:0] coef(input int k);
        logic [63:0] h;
        h = 64'(k) * 64'h9E37_79B9;
        if (k >= NCOEF) return '0;
        case (k)
            0:       return {1'b1, {(W-1){1'b0}}};
            1:       return {1'b0, {(W-1){1'b1}}};
            2:       return '0;
            3:       return '1;
            default: return h[W-1:0];
        endcase
    endfunction

    function automatic logic [PW-1:0] expect_prod(input logic [W-1:0] x, input int k);
        logic signed [PW-1:0] a, b;
        a = PW'(signed'(x));
        b = PW'(coef(k));
        return a * b;
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one operand, then check both instances on the next falling edge.
    task automatic apply(input string req, input logic [W-1:0] x, input int k);
        logic [PW-1:0] e;
        e = expect_prod(x, k);
        @(negedge clk);
        in_valid = 1'b1; in_x = x; in_idx = IDXW'(k);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_prod, e);
        check({req, " R8 mirror"}, out_prod_m, e);
        check({req, " R4 valid"}, PW'(out_valid), PW'(1));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R6 valid in reset", PW'(out_valid), '0);
        check("R6 product in reset", out_prod, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_all_entries();
        for (int k = 0; k < NCOEF; k++) begin
            apply("R1 R2 entry", 16'h0001, k);
            apply("R1 R2 entry", 16'h1234, k);
            apply("R1 R2 entry", 16'hFFFF, k);
            apply("R1 R2 entry", 16'hA5C3, k);
        end
    endtask

    task automatic t_extremes();
        apply("R7 min*min", 16'h8000, 0);
        check("R7 min*min literal", out_prod, 32'h4000_0000);
        apply("R7 max*min", 16'h7FFF, 0);
        apply("R7 min*max", 16'h8000, 1);
        apply("R7 max*max", 16'h7FFF, 1);
        apply("R7 min*-1", 16'h8000, 3);
        check("R7 min*-1 literal", out_prod, 32'h0000_8000);
    endtask

    task automatic t_out_of_range();
        for (int k = NCOEF; k < (1 << IDXW); k++) begin
            apply("R3 index beyond table", 16'h7FFF, k);
        end
    endtask

    task automatic t_hold();
        logic [PW-1:0] e;
        apply("R5 setup", 16'h0123, 5);
        e = expect_prod(16'h0123, 5);
        @(negedge clk); in_x = 16'h8000; in_idx = 4'd1;
        @(negedge clk); in_x = 16'h7777; in_idx = 4'd7;
        @(negedge clk);
        check("R5 hold without valid", out_prod, e);
        check("R5 hold mirror", out_prod_m, e);
        check("R4 valid low", PW'(out_valid), '0);
    endtask

    task automatic t_stream();
        logic [W-1:0]  xs [8];
        logic [PW-1:0] e;
        for (int i = 0; i < 8; i++) xs[i] = W'($urandom);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i > 0) begin
                e = expect_prod(xs[i-1], (i - 1) % NCOEF);
                check("R9 stream", out_prod, e);
                check("R9 stream mirror", out_prod_m, e);
            end
            in_valid = 1'b1; in_x = xs[i]; in_idx = IDXW'(i % NCOEF);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 stream last", out_prod, expect_prod(xs[7], 7));
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            apply("R1 random", W'($urandom), int'($urandom_range(0, NCOEF - 1)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_all_entries();
        t_extremes();
        t_out_of_range();
        t_hold();
        t_stream();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule